// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (SMBus or I2C style). It oversamples the bus clock and data lines with a faster system clock and cleans them up. It recognises START, repeated START and STOP conditions, and it answers a single fixed 7-bit device address. Once addressed, it gives the bus master access to an external register file whose entries are two bytes wide.

A write transaction always opens with a pointer byte. That byte selects the register, and any further bytes in the same transaction are handed to the register file as byte writes. The first of those bytes goes to the high byte, and later bytes alternate between low and high. A read transaction returns the register named by the most recently stored pointer, high byte first, MSB first. The pointer survives STOP, repeated START and address mismatches, so repeated reads of one register need no new pointer byte.

The data line is driven only through an open-drain enable: when `sda_oe` is high, the line is pulled low. The register file is external. It presents the contents of the entry at `rf_ptr` on `rf_rdata` and accepts one-cycle byte-write strobes.

Top module: `smb_ptr_slave`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the slave to idle from any point, even in the middle of a byte. After a STOP, `sda_oe` is 0, no register write is issued, and `rf_ptr` keeps its value.
- R2: The slave acknowledges only the address byte whose upper seven bits are 7'b1001100; bit 0 of that byte is the direction (0 = write, 1 = read). The acknowledge holds SDA low through the high phase of the ninth clock. For any other address the slave never drives SDA until the next START.
- R3: In a write transaction, the first byte after the address is acknowledged and loaded into `rf_ptr`. A transaction that ends right after this pointer byte is valid.
- R4: Each later byte in a write transaction is acknowledged and produces exactly one single-cycle `rf_we` pulse, carrying the byte on `rf_wdata`. `rf_wsel_hi` is 1 for the first data byte after the pointer and then alternates 0, 1, 0, and so on.
- R5: In a read transaction, bytes are sent MSB first. The first byte is `rf_rdata[15:8]`, and each byte the master acknowledges is followed by the other half of `rf_rdata`. The slave emits a 0 bit by asserting `sda_oe` and a 1 bit by releasing it.
- R6: The pointer is kept across transactions. A read with no pointer byte before it returns the register chosen by the last pointer byte written.
- R7: A not-acknowledge from the master after a read byte ends the transfer. The slave releases SDA and drives nothing more until the next START.
- R8: A repeated START at any point restarts address reception. The slave releases SDA, and the following read begins at the high byte.
- R9: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks (default 3) after synchronisation is ignored and does not disturb the transfer.
- R10: `sda_oe` changes only just after a filtered falling edge of SCL, or on a START or STOP. It never changes while the bus clock is high in a valid transfer.
- R11: While reset is active and directly after it, `sda_oe` = 0, `rf_we` = 0 and `rf_ptr` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | When high, pulls the data line low |
| rf_ptr | output | PTR_W | Stored register pointer, used as the register-file read and write index |
| rf_rdata | input | 16 | Contents of the register selected by `rf_ptr` |
| rf_we | output | 1 | One-cycle byte write strobe |
| rf_wsel_hi | output | 1 | Byte lane of the write: 1 = high byte, 0 = low byte |
| rf_wdata | output | 8 | Byte to be written |

## Verification
Each line reaches the edge logic through two synchroniser flops and a FILT_LEN-sample filter, so every bus event acts about five system clocks after the line moves. Acknowledge and read-data levels therefore settle a few clocks after each SCL fall, and the bench holds every bus phase for 16 clocks and samples SDA in the middle of the SCL high phase. Write strobes appear one clock after the filtered falling edge of the eighth bit; a monitor that runs alongside the driver takes them from a queue in order, whenever they appear. Pointer and idle-state checks are made after the STOP phase has fully elapsed.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } smb_state_e;

endpackage

// File: rtl/smb_rst_sync.sv
module smb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= {hold_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sn = hold_q[STAGES-1];

endmodule

// File: rtl/smb_glitch_filt.sv
module smb_glitch_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic din,
  output logic dout
);

  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   out_q, out_d;
  logic                   differ;

  // metastability chain, idle bus level is high
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end
  end

  assign differ = sync_q[SYNC_STAGES-1] != out_q;

  // output follows only after FILT_LEN consecutive differing samples
  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (differ) begin
      if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        out_d = ~out_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;

endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk,
  input  logic rst_sn,
  input  logic scl_f,
  input  logic sda_f,
  output logic evt_rise,
  output logic evt_fall,
  output logic evt_start,
  output logic evt_stop
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign evt_rise  = scl_f & ~scl_q;
  assign evt_fall  = ~scl_f & scl_q;
  // data moving while the clock stays high is a bus condition
  assign evt_start = scl_f & scl_q & sda_q & ~sda_f;
  assign evt_stop  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/smb_ptr_engine.sv
module smb_ptr_engine
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C,
  parameter int         PTR_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_sn,
  input  logic                  sda_f,
  input  logic                  evt_rise,
  input  logic                  evt_fall,
  input  logic                  evt_start,
  input  logic                  evt_stop,
  input  logic [REG_W-1:0]      rf_rdata,
  output logic                  sda_oe,
  output logic [PTR_W-1:0]      rf_ptr,
  output logic                  rf_we,
  output logic                  rf_wsel_hi,
  output logic [BYTE_W-1:0]     rf_wdata
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  smb_state_e          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   rx_q, rx_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic                oe_q, oe_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic                first_q, first_d;
  logic                hi_q, hi_d;
  logic                rw_q, rw_d;
  logic                mack_q, mack_d;
  logic                we_q, we_d;
  logic                wsel_q, wsel_d;
  logic [BYTE_W-1:0]   wdata_q, wdata_d;
  logic [BYTE_W-1:0]   hi_byte, lo_byte, next_byte;
  logic                byte_done;

  assign hi_byte   = rf_rdata[REG_W-1 -: BYTE_W];
  assign lo_byte   = rf_rdata[BYTE_W-1:0];
  assign byte_done = evt_fall && (cnt_q == CNT_W'(BYTE_W));
  // after an acknowledged read byte the other half follows
  assign next_byte = hi_q ? lo_byte : hi_byte;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    oe_d    = oe_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    hi_d    = hi_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    we_d    = 1'b0;
    wsel_d  = wsel_q;
    wdata_d = wdata_q;

    if (evt_stop) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (evt_start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      first_d = 1'b1;
      hi_d    = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_WR_BYTE: begin
          if (evt_rise) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end else if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
                state_d = ST_ADDR_ACK;
                rw_d    = rx_q[0];
                oe_d    = 1'b1;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              if (first_q) begin
                ptr_d   = rx_q[PTR_W-1:0];
                first_d = 1'b0;
              end else begin
                we_d    = 1'b1;
                wsel_d  = hi_q;
                wdata_d = rx_q;
                hi_d    = ~hi_q;
              end
              state_d = ST_WR_ACK;
              oe_d    = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (evt_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RD_BYTE;
              tx_d    = hi_q ? hi_byte : lo_byte;
              oe_d    = hi_q ? ~hi_byte[BYTE_W-1] : ~lo_byte[BYTE_W-1];
            end else begin
              state_d = ST_WR_BYTE;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (evt_fall) begin
            state_d = ST_WR_BYTE;
            cnt_d   = '0;
            oe_d    = 1'b0;
          end
        end
        ST_RD_BYTE: begin
          if (evt_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (byte_done) begin
            state_d = ST_RD_ACK;
            oe_d    = 1'b0;
          end else if (evt_fall) begin
            tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            oe_d = ~tx_q[BYTE_W-2];
          end
        end
        ST_RD_ACK: begin
          if (evt_rise) begin
            mack_d = ~sda_f;
          end else if (evt_fall) begin
            if (mack_q) begin
              state_d = ST_RD_BYTE;
              cnt_d   = '0;
              hi_d    = ~hi_q;
              tx_d    = next_byte;
              oe_d    = ~next_byte[BYTE_W-1];
            end else begin
              state_d = ST_IDLE;
              oe_d    = 1'b0;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      ptr_q   <= '0;
      first_q <= 1'b1;
      hi_q    <= 1'b1;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
      wsel_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      oe_q    <= oe_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
      hi_q    <= hi_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      we_q    <= we_d;
      wsel_q  <= wsel_d;
      wdata_q <= wdata_d;
    end
  end

  assign sda_oe     = oe_q;
  assign rf_ptr     = ptr_q;
  assign rf_we      = we_q;
  assign rf_wsel_hi = wsel_q;
  assign rf_wdata   = wdata_q;

endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  rf_ptr,
  input  logic [15:0]       rf_rdata,
  output logic              rf_we,
  output logic              rf_wsel_hi,
  output logic [7:0]        rf_wdata
);

  localparam int LINES = 2;

  logic             rst_sn;
  logic [LINES-1:0] line_raw, line_f;
  logic             evt_rise, evt_fall, evt_start, evt_stop;

  smb_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    smb_glitch_filt #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst_sn (rst_sn),
      .din    (line_raw[g]),
      .dout   (line_f[g])
    );
  end

  smb_bus_cond u_cond (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .scl_f     (line_f[0]),
    .sda_f     (line_f[1]),
    .evt_rise  (evt_rise),
    .evt_fall  (evt_fall),
    .evt_start (evt_start),
    .evt_stop  (evt_stop)
  );

  smb_ptr_engine #(
    .DEV_ADDR (DEV_ADDR),
    .PTR_W    (PTR_W)
  ) u_eng (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .sda_f      (line_f[1]),
    .evt_rise   (evt_rise),
    .evt_fall   (evt_fall),
    .evt_start  (evt_start),
    .evt_stop   (evt_stop),
    .rf_rdata   (rf_rdata),
    .sda_oe     (sda_oe),
    .rf_ptr     (rf_ptr),
    .rf_we      (rf_we),
    .rf_wsel_hi (rf_wsel_hi),
    .rf_wdata   (rf_wdata)
  );

endmodule

// File: rtl/smb_ptr_checker.sv
module smb_ptr_checker #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             sda_oe,
  input logic             rf_we,
  input logic [PTR_W-1:0] rf_ptr,
  input logic             evt_fall,
  input logic             evt_start,
  input logic             evt_stop
);

  // R10: drive level moves only after a clock fall or a bus condition
  p_oe_timing_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !$stable(sda_oe) |-> $past(evt_fall || evt_start || evt_stop));

  // R4: a write strobe lasts one cycle
  p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    rf_we |=> !rf_we);

  // R4: a write strobe follows a clock fall that closes a byte
  p_we_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    rf_we |-> $past(evt_fall));

  // R1: a stop leaves the line released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    evt_stop |=> !sda_oe);

  // R8: a start leaves the line released
  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    evt_start |=> !sda_oe);

  // R6: a stop never alters the pointer
  p_stop_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    evt_stop |=> $stable(rf_ptr));

endmodule

bind smb_ptr_slave smb_ptr_checker #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .sda_oe    (sda_oe),
  .rf_we     (rf_we),
  .rf_ptr    (rf_ptr),
  .evt_fall  (evt_fall),
  .evt_start (evt_start),
  .evt_stop  (evt_stop)
);

// File: tb/smb_ptr_slave_test.sv
`timescale 1ns/1ps
module smb_ptr_slave_test;

  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [7:0] rf_ptr;
  logic [15:0] rf_rdata;
  logic       rf_we, rf_wsel_hi;
  logic [7:0] rf_wdata;
  logic       glitch_on = 1'b0;
  logic       done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int oe_viol = 0;
  logic [8:0] exp_wr[$];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  function automatic logic [15:0] model(input logic [7:0] p);
    return {p ^ 8'hA5, ~p};
  endfunction

  assign rf_rdata = model(rf_ptr);

  smb_ptr_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .rf_ptr     (rf_ptr),
    .rf_rdata   (rf_rdata),
    .rf_we      (rf_we),
    .rf_wsel_hi (rf_wsel_hi),
    .rf_wdata   (rf_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(Q);
    if (glitch_on) begin
      scl = 1'b0;  tick(1);
      scl = 1'b1;  tick(2);
      sda_m = ~b;  tick(1);
      sda_m = b;   tick(2);
    end
    s = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      v = {v[6:0], s};
    end
    bus_bit(~mack, s);
  endtask

  // scoreboard monitor for register writes
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      if (exp_wr.size() == 0) begin
        chk(1'b0, "R4 unexpected write", {rf_wsel_hi, rf_wdata}, 0);
      end else begin
        logic [8:0] e;
        e = exp_wr.pop_front();
        chk({rf_wsel_hi, rf_wdata} == e, "R4 write byte", {rf_wsel_hi, rf_wdata}, e);
      end
    end
  end

  // R10 monitor: drive level must not move while the bus clock is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe != oe_prev)) oe_viol++;
    oe_prev <= sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       a;
    logic [7:0] v;
    logic       s;
    logic       all_hi;

    tick(5);
    chk(sda_oe == 1'b0, "R11 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe == 1'b0 && rf_we == 1'b0, "R11 oe/we after reset", {sda_oe, rf_we}, 0);
    chk(rf_ptr == 8'h00, "R11 ptr after reset", rf_ptr, 0);
    tick(Q);

    // pointer-only write
    bus_start;
    wr_byte(8'h98, a); chk(a, "R2 address ack", a, 1);
    wr_byte(8'h12, a); chk(a, "R3 pointer ack", a, 1);
    bus_stop;
    chk(rf_ptr == 8'h12, "R3 pointer loaded", rf_ptr, 8'h12);

    // pointer plus three data bytes
    bus_start;
    wr_byte(8'h98, a); chk(a, "R2 address ack", a, 1);
    wr_byte(8'h05, a); chk(a, "R3 pointer ack", a, 1);
    exp_wr.push_back({1'b1, 8'hAB});
    wr_byte(8'hAB, a); chk(a, "R4 data ack", a, 1);
    exp_wr.push_back({1'b0, 8'hCD});
    wr_byte(8'hCD, a); chk(a, "R4 data ack", a, 1);
    exp_wr.push_back({1'b1, 8'hEF});
    wr_byte(8'hEF, a); chk(a, "R4 data ack", a, 1);
    bus_stop;
    chk(rf_ptr == 8'h05, "R3 pointer loaded", rf_ptr, 8'h05);

    // read three bytes, the last one not acknowledged
    bus_start;
    wr_byte(8'h99, a); chk(a, "R2 read address ack", a, 1);
    rd_byte(1'b1, v); chk(v == 8'hA0, "R5 high byte", v, 8'hA0);
    rd_byte(1'b1, v); chk(v == 8'hFA, "R5 low byte", v, 8'hFA);
    rd_byte(1'b0, v); chk(v == 8'hA0, "R5 wrap to high", v, 8'hA0);
    all_hi = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      all_hi = all_hi & s;
    end
    chk(all_hi, "R7 released after nack", all_hi, 1);
    bus_stop;

    // read again with no new pointer
    bus_start;
    wr_byte(8'h99, a); chk(a, "R6 read address ack", a, 1);
    rd_byte(1'b0, v); chk(v == 8'hA0, "R6 pointer kept", v, 8'hA0);
    bus_stop;

    // foreign address
    bus_start;
    wr_byte(8'h9A, a); chk(!a, "R2 no ack foreign address", a, 0);
    wr_byte(8'h00, a); chk(!a, "R2 silent after mismatch", a, 0);
    bus_stop;
    chk(rf_ptr == 8'h05, "R2 pointer untouched", rf_ptr, 8'h05);

    // repeated start from write to read
    bus_start;
    wr_byte(8'h98, a); chk(a, "R8 address ack", a, 1);
    wr_byte(8'h21, a); chk(a, "R8 pointer ack", a, 1);
    bus_start;
    wr_byte(8'h99, a); chk(a, "R8 address ack after restart", a, 1);
    rd_byte(1'b0, v); chk(v == 8'h84, "R8 read after restart", v, 8'h84);
    bus_stop;

    // address only then stop
    bus_start;
    wr_byte(8'h98, a); chk(a, "R1 address ack", a, 1);
    bus_stop;
    chk(rf_ptr == 8'h21, "R1 pointer kept over stop", rf_ptr, 8'h21);

    // stop in the middle of a data byte
    bus_start;
    wr_byte(8'h98, a);
    wr_byte(8'h30, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
    bus_stop;
    chk(sda_oe == 1'b0, "R1 released after mid-byte stop", sda_oe, 0);
    chk(rf_ptr == 8'h30, "R1 pointer after mid-byte stop", rf_ptr, 8'h30);

    // short spikes on both lines
    glitch_on = 1'b1;
    bus_start;
    wr_byte(8'h98, a); chk(a, "R9 address ack with spikes", a, 1);
    wr_byte(8'h40, a); chk(a, "R9 pointer ack with spikes", a, 1);
    exp_wr.push_back({1'b1, 8'h5A});
    wr_byte(8'h5A, a); chk(a, "R9 data ack with spikes", a, 1);
    bus_stop;
    glitch_on = 1'b0;
    chk(rf_ptr == 8'h40, "R9 pointer with spikes", rf_ptr, 8'h40);

    bus_start;
    wr_byte(8'h99, a);
    rd_byte(1'b0, v); chk(v == 8'hE5, "R9 read after spikes", v, 8'hE5);
    bus_stop;
    tick(Q);

    chk(exp_wr.size() == 0, "R4 all writes seen", exp_wr.size(), 0);
    chk(oe_viol == 0, "R10 oe moved with SCL high", oe_viol, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule